// File: doc/BRIEF.md
# Serial Flash Page Programming Sequencer

This block sits on the host side of a link to a target that accepts in-system programming over a four-wire serial port. A single `start` pulse makes it hold the target in reset and wait out the power-up delay. It then sends the four-byte programming-enable instruction and checks the echo the target returns. If the target is out of sync, it pulses reset and tries again. Once the link is in sync, it pulls one page of 16-bit words from a valid/ready stream and loads each word as two byte instructions, the low byte first. It then commits the page and waits for the write to finish.

The write is detected as finished by reading back the first byte of the page that is not erased-all-ones, until the target returns the programmed value. If every byte of the page is 0xFF, polling cannot tell a finished write from one still in progress, so the block waits a fixed number of cycles instead. At the end the block pulses `done`, reports `err`, and releases the target's reset.

The word stream follows normal valid/ready rules. A word transfers on a clock edge where both `wd_valid` and `wd_ready` are high. The source must hold `wd_data` steady while `wd_valid` is high and no transfer has happened. `wd_ready` is raised only when the serial engine is idle and the next word is due, so the source may stall for any number of cycles.

Top module: `isp_page_writer`

## Requirements
- R1: After reset, `isp_rst` is high (target running), `isp_sck` is low, and `busy`, `done` and `wd_ready` are low.
- R2: On `start`, `isp_rst` goes low and no serial clock edge occurs for at least PWR_WAIT cycles. The first frame is then the enable instruction, bytes 0xAC 0x53 0x00 0x00.
- R3: Each frame is 32 bits, most significant bit first. `isp_sck` idles low and runs at no more than a quarter of the system clock. `isp_mosi` never changes while `isp_sck` is high, and `isp_miso` is sampled on the rising edge.
- R4: The link is in sync when the byte received during the third byte of the enable frame is 0x53. Otherwise the full frame is still sent, then `isp_rst` is driven high for at least RST_PULSE cycles and low again, then the wait and the enable frame are repeated.
- R5: After MAX_RETRY repeated attempts have also failed, `done` pulses with `err` high, and no load frame is sent.
- R6: Word i of the page is sent as 0x40 0x00 i low-byte, then as 0x48 0x00 i high-byte. The low byte is always loaded before the high byte of the same index.
- R7: A word is taken only on a cycle with `wd_valid` and `wd_ready` both high. `wd_ready` is never high while a frame is in flight. The words fill indices 0 upward, in stream order.
- R8: After the last word, a single commit frame 0x4C addr[15:8] addr[7:0] 0x00 is sent, where addr = {page_num, zeros}.
- R9: If any loaded byte is not 0xFF, the first such byte (in the order low of word 0, high of word 0, low of word 1, ...) is polled. The poll uses read frames 0x20 (low byte) or 0x28 (high byte) with addr[15:8] addr[7:0] 0x00, repeated until the fourth received byte equals that byte. `done` then pulses with `err` low.
- R10: If every loaded byte is 0xFF, no read frame is sent, and `done` pulses at least FLASH_WAIT cycles after the commit frame ends.
- R11: Between the commit frame and `done`, only read frames are sent.
- R12: In the cycle `done` is high, `busy` is low and `isp_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a page programming run when idle |
| page_num | input | ADDR_W-PAGE_BITS | Page number, sampled at start |
| wd_valid | input | 1 | Page word stream valid |
| wd_ready | output | 1 | Page word stream ready |
| wd_data | input | 16 | Page word, high byte in bits 15:8 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| err | output | 1 | Sync retries exhausted; valid with done, held until next start |
| isp_rst | output | 1 | Target reset pin level, low holds target in programming mode |
| isp_sck | output | 1 | Serial clock to target |
| isp_mosi | output | 1 | Serial data to target |
| isp_miso | input | 1 | Serial data from target |

## Verification
A frame takes 64*SCK_HALF system cycles. The echo and the polled byte are judged in the cycle that frame completes, so the bench's target model decodes each frame on the 32nd rising serial edge and looks only at totals and timestamps after `done`. The wait windows are checked as cycle differences between events: from start to the first serial rising edge (PWR_WAIT), across each reset-high stretch (RST_PULSE), and from the commit frame's last edge to `done` (FLASH_WAIT, or the target's own busy time when polling). `done`, `busy` and `isp_rst` are sampled at the falling clock edge of the cycle in which `done` is high. The stream source checks `wd_ready` at the falling edge, so each word transfers at the following rising edge.

// File: rtl/isp_pkg.sv
package isp_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PWR,
    S_EN,
    S_PULSE,
    S_WORD,
    S_LLO,
    S_LHI,
    S_WPG,
    S_POLL,
    S_TOUT
  } isp_state_e;

  localparam logic [7:0] OP_EN_A    = 8'hAC;
  localparam logic [7:0] OP_EN_B    = 8'h53;
  localparam logic [7:0] OP_LD_LO   = 8'h40;
  localparam logic [7:0] OP_LD_HI   = 8'h48;
  localparam logic [7:0] OP_WR_PAGE = 8'h4C;
  localparam logic [7:0] OP_RD_LO   = 8'h20;
  localparam logic [7:0] OP_RD_HI   = 8'h28;
  localparam logic [7:0] BYTE_BLANK = 8'hFF;

  function automatic logic [31:0] pack4(input logic [7:0] b0, input logic [7:0] b1,
                                        input logic [7:0] b2, input logic [7:0] b3);
    return {b0, b1, b2, b3};
  endfunction

endpackage

// File: rtl/isp_frame.sv
// Serial engine: shifts one 32-bit frame, MSB first, SCK idle low.
module isp_frame #(
  parameter int SCK_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] tx,
  input  logic        miso,
  output logic        busy,
  output logic        done,
  output logic [15:0] rx,
  output logic        sck,
  output logic        mosi
);
  localparam int HALF = (SCK_HALF < 2) ? 2 : SCK_HALF;
  localparam int HW   = $clog2(HALF + 1);

  logic [HW-1:0] hcnt;
  logic [4:0]    nbit;
  logic [31:0]   sh;
  logic [15:0]   rxr;
  logic          act, sck_r, done_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt   <= '0;
      nbit   <= '0;
      sh     <= '0;
      rxr    <= '0;
      act    <= 1'b0;
      sck_r  <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (!act) begin
        if (start) begin
          act   <= 1'b1;
          sh    <= tx;
          nbit  <= '0;
          hcnt  <= '0;
          sck_r <= 1'b0;
        end
      end else if (hcnt == HW'(HALF - 1)) begin
        hcnt <= '0;
        if (!sck_r) begin
          sck_r <= 1'b1;
          rxr   <= {rxr[14:0], miso};
        end else begin
          sck_r <= 1'b0;
          sh    <= {sh[30:0], 1'b0};
          if (nbit == 5'd31) begin
            act    <= 1'b0;
            done_r <= 1'b1;
          end else begin
            nbit <= nbit + 5'd1;
          end
        end
      end else begin
        hcnt <= hcnt + HW'(1);
      end
    end
  end

  assign busy = act;
  assign done = done_r;
  assign rx   = rxr;
  assign sck  = sck_r;
  assign mosi = sh[31];

  // R3: data to the target holds across every high phase of the clock
  a_r3_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_r && $past(sck_r)) |-> $stable(sh[31]));
  // R3: serial clock is low whenever no frame is in flight
  a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> !sck_r);
  // R3: a frame ends with the clock low
  a_r3_end_low: assert property (@(posedge clk) disable iff (!rst_n)
    done_r |-> (!sck_r && !act));

endmodule

// File: rtl/isp_wait_timer.sv
// Elapsed-cycle counter, restarted by a pulse, saturating at all ones.
module isp_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (restart)         cnt <= '0;
    else if (cnt != {W{1'b1}}) cnt <= cnt + W'(1);
  end

  a_r2_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
endmodule

// File: rtl/isp_poll_pick.sv
// Remembers the first non-blank byte of the page, in load order.
module isp_poll_pick #(
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          take,
  input  logic [IW-1:0] idx,
  input  logic [15:0]   data,
  output logic          have,
  output logic          hi,
  output logic [IW-1:0] sel_idx,
  output logic [7:0]    val
);
  import isp_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have    <= 1'b0;
      hi      <= 1'b0;
      sel_idx <= '0;
      val     <= '0;
    end else if (clr) begin
      have <= 1'b0;
    end else if (take && !have) begin
      if (data[7:0] != BYTE_BLANK) begin
        have    <= 1'b1;
        hi      <= 1'b0;
        sel_idx <= idx;
        val     <= data[7:0];
      end else if (data[15:8] != BYTE_BLANK) begin
        have    <= 1'b1;
        hi      <= 1'b1;
        sel_idx <= idx;
        val     <= data[15:8];
      end
    end
  end

  // R9: once chosen, the polled byte does not move until the next run
  a_r9_pick_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (have && !clr) |=> (have && $stable(val) && $stable(sel_idx) && $stable(hi)));
  // R9: a chosen byte is never the blank value
  a_r9_pick_nonblank: assert property (@(posedge clk) disable iff (!rst_n)
    have |-> (val != BYTE_BLANK));
endmodule

// File: rtl/isp_page_writer.sv
module isp_page_writer #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BITS  = 5,
  parameter int SCK_HALF   = 2,
  parameter int PWR_WAIT   = 5000000,
  parameter int RST_PULSE  = 500,
  parameter int FLASH_WAIT = 1125000,
  parameter int MAX_RETRY  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [ADDR_W-PAGE_BITS-1:0] page_num,
  input  logic                        wd_valid,
  output logic                        wd_ready,
  input  logic [15:0]                 wd_data,
  output logic                        busy,
  output logic                        done,
  output logic                        err,
  output logic                        isp_rst,
  output logic                        isp_sck,
  output logic                        isp_mosi,
  input  logic                        isp_miso
);
  import isp_pkg::*;

  localparam int PN_W  = ADDR_W - PAGE_BITS;
  localparam int TMAX0 = (PWR_WAIT > RST_PULSE) ? PWR_WAIT : RST_PULSE;
  localparam int TMAX  = (TMAX0 > FLASH_WAIT) ? TMAX0 : FLASH_WAIT;
  localparam int TW    = $clog2(TMAX + 2);
  localparam int RW    = $clog2(MAX_RETRY + 2);
  localparam logic [PAGE_BITS-1:0] LAST_IDX = {PAGE_BITS{1'b1}};

  isp_state_e          state;
  logic [PN_W-1:0]     pg;
  logic [PAGE_BITS-1:0] widx;
  logic [15:0]         word;
  logic [RW-1:0]       tries;
  logic                issued, rst_pin, done_r, err_r, tm_restart;

  logic                fr_start, fr_busy, fr_done;
  logic [31:0]         fr_tx;
  logic [15:0]         fr_rx;
  logic [TW-1:0]       tm_cnt;
  logic                pk_have, pk_hi;
  logic [PAGE_BITS-1:0] pk_idx;
  logic [7:0]          pk_val;
  logic [15:0]         page16, poll16;
  logic                frame_state, take_word, start_run;

  assign page16    = 16'({pg, {PAGE_BITS{1'b0}}});
  assign poll16    = 16'({pg, pk_idx});
  assign take_word = (state == S_WORD) && wd_valid;
  assign start_run = (state == S_IDLE) && start;

  always_comb begin
    fr_tx = '0;
    unique case (state)
      S_EN:    fr_tx = pack4(OP_EN_A, OP_EN_B, 8'h00, 8'h00);
      S_LLO:   fr_tx = pack4(OP_LD_LO, 8'h00, 8'(widx), word[7:0]);
      S_LHI:   fr_tx = pack4(OP_LD_HI, 8'h00, 8'(widx), word[15:8]);
      S_WPG:   fr_tx = pack4(OP_WR_PAGE, page16[15:8], page16[7:0], 8'h00);
      S_POLL:  fr_tx = pack4(pk_hi ? OP_RD_HI : OP_RD_LO, poll16[15:8], poll16[7:0], 8'h00);
      default: fr_tx = '0;
    endcase
  end

  assign frame_state = (state == S_EN) || (state == S_LLO) || (state == S_LHI) ||
                       (state == S_WPG) || (state == S_POLL);
  assign fr_start    = frame_state && !issued;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      pg         <= '0;
      widx       <= '0;
      word       <= '0;
      tries      <= '0;
      issued     <= 1'b0;
      rst_pin    <= 1'b1;
      done_r     <= 1'b0;
      err_r      <= 1'b0;
      tm_restart <= 1'b0;
    end else begin
      done_r     <= 1'b0;
      tm_restart <= 1'b0;
      if (fr_start) issued <= 1'b1;
      unique case (state)
        S_IDLE: begin
          rst_pin <= 1'b1;
          if (start) begin
            pg         <= page_num;
            tries      <= '0;
            err_r      <= 1'b0;
            rst_pin    <= 1'b0;
            tm_restart <= 1'b1;
            state      <= S_PWR;
          end
        end
        S_PWR: begin
          if (!tm_restart && (tm_cnt >= TW'(PWR_WAIT - 1))) begin
            issued <= 1'b0;
            state  <= S_EN;
          end
        end
        S_EN: begin
          if (issued && fr_done) begin
            issued <= 1'b0;
            if (fr_rx[15:8] == OP_EN_B) begin
              widx  <= '0;
              state <= S_WORD;
            end else if (tries == RW'(MAX_RETRY)) begin
              err_r   <= 1'b1;
              done_r  <= 1'b1;
              rst_pin <= 1'b1;
              state   <= S_IDLE;
            end else begin
              tries      <= tries + RW'(1);
              rst_pin    <= 1'b1;
              tm_restart <= 1'b1;
              state      <= S_PULSE;
            end
          end
        end
        S_PULSE: begin
          if (!tm_restart && (tm_cnt >= TW'(RST_PULSE - 1))) begin
            rst_pin    <= 1'b0;
            tm_restart <= 1'b1;
            state      <= S_PWR;
          end
        end
        S_WORD: begin
          if (wd_valid) begin
            word   <= wd_data;
            issued <= 1'b0;
            state  <= S_LLO;
          end
        end
        S_LLO: begin
          if (issued && fr_done) begin
            issued <= 1'b0;
            state  <= S_LHI;
          end
        end
        S_LHI: begin
          if (issued && fr_done) begin
            issued <= 1'b0;
            if (widx == LAST_IDX) begin
              state <= S_WPG;
            end else begin
              widx  <= widx + PAGE_BITS'(1);
              state <= S_WORD;
            end
          end
        end
        S_WPG: begin
          if (issued && fr_done) begin
            issued <= 1'b0;
            if (pk_have) begin
              state <= S_POLL;
            end else begin
              tm_restart <= 1'b1;
              state      <= S_TOUT;
            end
          end
        end
        S_POLL: begin
          if (issued && fr_done) begin
            issued <= 1'b0;
            if (fr_rx[7:0] == pk_val) begin
              done_r  <= 1'b1;
              rst_pin <= 1'b1;
              state   <= S_IDLE;
            end
          end
        end
        S_TOUT: begin
          if (!tm_restart && (tm_cnt >= TW'(FLASH_WAIT - 1))) begin
            done_r  <= 1'b1;
            rst_pin <= 1'b1;
            state   <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  isp_frame #(.SCK_HALF(SCK_HALF)) u_frame (
    .clk   (clk),
    .rst_n (rst_n),
    .start (fr_start),
    .tx    (fr_tx),
    .miso  (isp_miso),
    .busy  (fr_busy),
    .done  (fr_done),
    .rx    (fr_rx),
    .sck   (isp_sck),
    .mosi  (isp_mosi)
  );

  isp_wait_timer #(.W(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tm_restart),
    .cnt     (tm_cnt)
  );

  isp_poll_pick #(.IW(PAGE_BITS)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start_run),
    .take    (take_word),
    .idx     (widx),
    .data    (wd_data),
    .have    (pk_have),
    .hi      (pk_hi),
    .sel_idx (pk_idx),
    .val     (pk_val)
  );

  assign wd_ready = (state == S_WORD);
  assign busy     = (state != S_IDLE);
  assign done     = done_r;
  assign err      = err_r;
  assign isp_rst  = rst_pin;

  // R2: no serial clock during the power-up wait or the reset pulse
  a_r2_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_PWR) || (state == S_PULSE)) |-> !isp_sck);
  // R4: a reset pulse follows only a frame whose echo was wrong
  a_r4_pulse_after_bad_echo: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_pin) && (state == S_PULSE)) |-> ($past(fr_done) && ($past(fr_rx[15:8]) != OP_EN_B)));
  // R5: error flag rises only together with done
  a_r5_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_r) |-> done_r);
  // R6: high byte load is entered only from the low byte load
  a_r6_low_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LHI) |-> (($past(state) == S_LLO) || ($past(state) == S_LHI)));
  // R7: no word accepted while a frame is shifting
  a_r7_no_accept_while_framing: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ready |-> !fr_busy);
  // R11: while the write is pending only read frames start
  a_r11_reads_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_POLL) && fr_start) |-> ((fr_tx[31:24] == OP_RD_LO) || (fr_tx[31:24] == OP_RD_HI)));
  // R12: done releases the target and drops busy
  a_r12_done_release: assert property (@(posedge clk) disable iff (!rst_n)
    done_r |-> (rst_pin && !busy));

endmodule

// File: tb/isp_page_writer_tb.sv
`timescale 1ns/1ps
module isp_page_writer_tb;
  localparam int AW = 16, PB = 3, PW = 1 << PB, HALF = 2;
  localparam int PWRW = 200, RSTP = 20, FLW = 300, MAXR = 2, TGT_BUSY = 150;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wd_valid = 1'b0, isp_miso = 1'b0;
  logic [AW-PB-1:0] page_num = '0;
  logic [15:0] wd_data = '0;
  logic wd_ready, busy, done, err, isp_rst, isp_sck, isp_mosi;

  always #2 clk = ~clk;

  isp_page_writer #(.ADDR_W(AW), .PAGE_BITS(PB), .SCK_HALF(HALF), .PWR_WAIT(PWRW),
    .RST_PULSE(RSTP), .FLASH_WAIT(FLW), .MAX_RETRY(MAXR)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .page_num(page_num),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .busy(busy), .done(done), .err(err), .isp_rst(isp_rst),
    .isp_sck(isp_sck), .isp_mosi(isp_mosi), .isp_miso(isp_miso));

  int total = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;

  // target model state
  logic [31:0] t_in = '0;
  int t_bit = 0, desync_left = 0;
  logic [7:0] b1 = '0, resp = '0;
  logic [7:0] pb_lo [PW], pb_hi [PW], fl_lo [PW], fl_hi [PW];
  bit lo_seen [PW];
  int busy_until = 0, en_cnt = 0, ld_cnt = 0, commit_cnt = 0, read_cnt = 0;
  int order_bad = 0, bad_busy = 0, commit_cyc = 0, first_sck = -1;
  logic [31:0] first_en = '0;
  logic [15:0] commit_addr = '0, last_rd_addr = '0;
  logic [7:0] last_rd_op = '0;

  // port monitors
  int mosi_bad = 0, sck_idle_bad = 0, falls = 0, hi_len = 0, min_pulse = 1 << 30;
  int ready_cnt = 0, done_cyc = 0, start_cyc = 0;
  bit done_seen = 1'b0, err_at_done = 1'b0, rel_ok = 1'b0;
  logic sck_p = 1'b0, mosi_p = 1'b0, rst_p = 1'b1;
  logic [15:0] exp_w [PW];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge isp_sck or posedge isp_rst) begin
    if (isp_rst) begin
      t_bit = 0;
      if (desync_left > 0) desync_left = desync_left - 1;
    end else begin
      if (first_sck < 0) first_sck = cyc;
      t_in = {t_in[30:0], isp_mosi};
      t_bit = t_bit + 1;
      if (t_bit == 16) b1 = t_in[7:0];
      if (t_bit == 24) begin
        int ix;
        ix = int'(t_in[PB-1:0]);
        if (cyc < busy_until) resp = 8'hFF;
        else resp = (t_in[23:16] == 8'h28) ? fl_hi[ix] : fl_lo[ix];
      end
      if (t_bit == 32) begin
        int ix;
        t_bit = 0;
        ix = int'(t_in[8+PB-1:8]);
        if (cyc < busy_until && t_in[31:24] != 8'h20 && t_in[31:24] != 8'h28)
          bad_busy = bad_busy + 1;
        case (t_in[31:24])
          8'hAC: begin if (en_cnt == 0) first_en = t_in; en_cnt = en_cnt + 1; end
          8'h40: begin pb_lo[ix] = t_in[7:0]; lo_seen[ix] = 1'b1; ld_cnt = ld_cnt + 1; end
          8'h48: begin
            if (!lo_seen[ix]) order_bad = order_bad + 1;
            pb_hi[ix] = t_in[7:0]; ld_cnt = ld_cnt + 1;
          end
          8'h4C: begin
            commit_addr = t_in[23:8]; commit_cnt = commit_cnt + 1; commit_cyc = cyc;
            busy_until = cyc + TGT_BUSY;
            for (int i = 0; i < PW; i++) begin fl_lo[i] = pb_lo[i]; fl_hi[i] = pb_hi[i]; end
          end
          8'h20, 8'h28: begin
            read_cnt = read_cnt + 1; last_rd_op = t_in[31:24]; last_rd_addr = t_in[23:8];
          end
          default: ;
        endcase
      end
    end
  end

  always @(negedge isp_sck) begin
    logic [7:0] echo;
    echo = (desync_left > 0) ? (b1 ^ 8'h10) : b1;
    if (t_bit >= 16 && t_bit < 24) isp_miso = echo[23 - t_bit];
    else if (t_bit >= 24 && t_bit < 32) isp_miso = resp[31 - t_bit];
    else isp_miso = 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (isp_sck && sck_p && isp_mosi != mosi_p) mosi_bad = mosi_bad + 1;
      if (!busy && isp_sck) sck_idle_bad = sck_idle_bad + 1;
      if (isp_rst) hi_len = hi_len + 1;
      if (rst_p && !isp_rst) begin
        falls = falls + 1;
        if (falls > 1 && hi_len < min_pulse) min_pulse = hi_len;
        hi_len = 0;
      end
      if (wd_ready) ready_cnt = ready_cnt + 1;
      if (done) begin
        done_seen = 1'b1; done_cyc = cyc; err_at_done = err;
        rel_ok = isp_rst && !busy;
      end
    end
    sck_p = isp_sck; mosi_p = isp_mosi; rst_p = isp_rst;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  function automatic int exp_pick_code();
    for (int i = 0; i < PW; i++) begin
      if (exp_w[i][7:0] != 8'hFF) return (i << 1);
      if (exp_w[i][15:8] != 8'hFF) return (i << 1) | 1;
    end
    return -1;
  endfunction

  task automatic run_page(input logic [AW-PB-1:0] pn, input int desync, input bit stall);
    int t0;
    for (int i = 0; i < PW; i++) begin
      pb_lo[i] = 8'hFF; pb_hi[i] = 8'hFF; fl_lo[i] = 8'hFF; fl_hi[i] = 8'hFF; lo_seen[i] = 1'b0;
    end
    en_cnt = 0; ld_cnt = 0; commit_cnt = 0; read_cnt = 0; order_bad = 0; bad_busy = 0;
    first_sck = -1; busy_until = 0; falls = 0; hi_len = 0; min_pulse = 1 << 30;
    ready_cnt = 0; done_seen = 1'b0; rel_ok = 1'b0; mosi_bad = 0; sck_idle_bad = 0;
    desync_left = desync;
    @(negedge clk);
    page_num = pn; start = 1'b1; start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    t0 = cyc;
    for (int i = 0; i < PW && !done_seen; i++) begin
      int gap;
      gap = stall ? int'($urandom % 6) : 0;
      repeat (gap) @(negedge clk);
      wd_valid = 1'b1; wd_data = exp_w[i];
      while (!wd_ready && !done_seen && (cyc - t0) < 20000) @(negedge clk);
      if (done_seen || (cyc - t0) >= 20000) begin wd_valid = 1'b0; break; end
      @(negedge clk);
      wd_valid = 1'b0;
    end
    while (!done_seen && (cyc - t0) < 20000) @(negedge clk);
    chk(done_seen, "R12", "watchdog, done seen", int'(done_seen), 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_success(input logic [AW-PB-1:0] pn, input int exp_en);
    int pk;
    chk(err_at_done == 1'b0, "R9", "err at done", int'(err_at_done), 0);
    chk(rel_ok, "R12", "release at done", int'(rel_ok), 1);
    chk(en_cnt == exp_en, "R4", "enable frames", en_cnt, exp_en);
    chk(first_en == 32'hAC530000, "R2", "enable frame", int'(first_en), 32'hAC530000);
    chk(first_sck - start_cyc >= PWRW, "R2", "power-up wait", first_sck - start_cyc, PWRW);
    chk(ld_cnt == 2 * PW, "R6", "load frames", ld_cnt, 2 * PW);
    chk(order_bad == 0, "R6", "high before low", order_bad, 0);
    for (int i = 0; i < PW; i++)
      chk({fl_hi[i], fl_lo[i]} == exp_w[i], "R7", "page word", int'({fl_hi[i], fl_lo[i]}), int'(exp_w[i]));
    chk(commit_cnt == 1, "R8", "commit frames", commit_cnt, 1);
    chk(commit_addr == 16'({pn, {PB{1'b0}}}), "R8", "commit addr", int'(commit_addr), int'(16'({pn, {PB{1'b0}}})));
    chk(bad_busy == 0, "R11", "non-read during write", bad_busy, 0);
    chk(mosi_bad == 0, "R3", "mosi change while sck high", mosi_bad, 0);
    chk(sck_idle_bad == 0, "R3", "sck high while idle", sck_idle_bad, 0);
    pk = exp_pick_code();
    if (pk < 0) begin
      chk(read_cnt == 0, "R10", "reads on blank page", read_cnt, 0);
      chk(done_cyc - commit_cyc >= FLW, "R10", "fixed wait", done_cyc - commit_cyc, FLW);
    end else begin
      chk(read_cnt > 0, "R9", "poll reads", read_cnt, 1);
      chk(done_cyc - commit_cyc >= TGT_BUSY, "R9", "done after write", done_cyc - commit_cyc, TGT_BUSY);
      chk(last_rd_op == ((pk & 1) ? 8'h28 : 8'h20), "R9", "poll opcode", int'(last_rd_op), (pk & 1) ? 32'h28 : 32'h20);
      chk(last_rd_addr == 16'({pn, PB'(pk >> 1)}), "R9", "poll addr", int'(last_rd_addr), int'(16'({pn, PB'(pk >> 1)})));
    end
  endtask

  initial begin
    logic [AW-PB-1:0] pn;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(isp_rst == 1'b1, "R1", "isp_rst in reset", int'(isp_rst), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(isp_rst == 1'b1 && isp_sck == 1'b0, "R1", "pins idle", int'({isp_rst, isp_sck}), 2);
    chk(!busy && !done && !wd_ready, "R1", "busy/done/ready", int'({busy, done, wd_ready}), 0);

    // random pages, with and without stalls (R6, R7, R9)
    for (int r = 0; r < 4; r++) begin
      pn = AW'($urandom) >> PB;
      for (int i = 0; i < PW; i++) exp_w[i] = 16'($urandom);
      run_page(pn, 0, r[0]);
      check_success(pn, 1);
    end

    // leading blank bytes: poll picks a later high byte (R9)
    for (int i = 0; i < PW; i++) exp_w[i] = 16'($urandom);
    exp_w[0] = 16'hFFFF; exp_w[1] = 16'h5AFF;
    pn = 13'h0155;
    run_page(pn, 0, 1'b1);
    check_success(pn, 1);

    // all blank page: fixed wait (R10)
    for (int i = 0; i < PW; i++) exp_w[i] = 16'hFFFF;
    run_page(13'h0A0A, 0, 1'b0);
    check_success(13'h0A0A, 1);

    // two bad echoes then sync (R4)
    for (int i = 0; i < PW; i++) exp_w[i] = 16'($urandom);
    pn = 13'h1F00;
    run_page(pn, MAXR, 1'b0);
    check_success(pn, MAXR + 1);
    chk(falls == MAXR + 1, "R4", "reset low transitions", falls, MAXR + 1);
    chk(min_pulse >= RSTP, "R4", "reset pulse width", min_pulse, RSTP);

    // retries exhausted (R5)
    run_page(13'h0001, MAXR + 1, 1'b0);
    chk(err_at_done == 1'b1, "R5", "err at done", int'(err_at_done), 1);
    chk(en_cnt == MAXR + 1, "R5", "enable frames", en_cnt, MAXR + 1);
    chk(ld_cnt == 0 && ready_cnt == 0, "R5", "loads after failure", ld_cnt + ready_cnt, 0);
    chk(rel_ok, "R12", "release after error", int'(rel_ok), 1);

    // recovery after error (R9)
    for (int i = 0; i < PW; i++) exp_w[i] = 16'($urandom);
    run_page(13'h0077, 0, 1'b1);
    check_success(13'h0077, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL R12 global watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule